// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block keeps one window register for each flash chip select of a memory-mapped flash controller. Each register places that slave's segment inside the controller's flash address window, with the start and the end given in 8 MB units. Every bus address is decoded to a chip-select index and a byte offset within the selected segment. An address that no enabled segment covers goes to a default region: no chip select is driven and a flag is raised.

Software updates a window register through a simple write port. The block validates each write in hardware before it takes effect:
- The start of chip select 0 is fixed to the window base.
- A window that lies wholly outside the flash window is refused.
- A misaligned window is accepted but flagged.
- A window that overlaps another chip select is accepted but flagged.

A small two-state machine runs the update. In ST_IDLE no update is pending. A valid write moves it to ST_APPLY, where the captured value is checked and committed at the next clock edge. From ST_APPLY it returns to ST_IDLE unless another write arrives, in which case it stays in ST_APPLY.

Top module: `cs_segment_decoder`

## Requirements
- R1: After reset the registers hold (start,end) in units of {base,base+8}, {base+8,base+12}, {base+12,base+16}, {base+16,base+20}, {base+20,base+24}, where base is the window base in 8 MB units (0x40 by default).
- R2: A register reads as end unit in bits 31:24, start unit in bits 23:16 and zero in bits 15:0. Bits 15:0 of written data are discarded. A read index of NUM_CS or above returns zero.
- R3: A write sampled at clock edge k is visible on the read port after edge k+1. Its error flags are high for exactly the one cycle after edge k+1.
- R4: A write to chip select 0 whose start differs from the window base is stored with the start replaced by the base and the written end kept, and err_cs0_fixed pulses.
- R5: A write whose end is at or below the window base, or whose start is above base plus window size, is refused. The register keeps its old value and err_rejected pulses. A start exactly equal to base plus window size is accepted.
- R6: A non-empty window whose start is not a multiple of its size (end minus start) is stored, and err_misaligned pulses.
- R7: A non-empty window that overlaps an enabled window of another chip select is stored, and err_overlap pulses.
- R8: A write equal to the current register content is ignored: the register is unchanged and no flag pulses.
- R9: A valid bus address with start*8MB <= address < end*8MB for some chip select sets bus_hit. It also sets the one-hot bit of that chip select in bus_cs_sel, puts its index on bus_cs_idx, and sets bus_offset to the address minus start*8MB.
- R10: A valid address that no enabled window covers raises bus_default, with bus_hit low, bus_cs_sel zero and bus_offset zero. With bus_valid low, all decode outputs are low.
- R11: When windows overlap, the lowest-numbered chip select that matches wins.
- R12: A window with end at or below start is disabled. It never matches, is never flagged as misaligned and never causes an overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Chip select whose register is written |
| wr_data | input | 32 | Write value (end in 31:24, start in 23:16) |
| rd_idx | input | IDX_W | Chip select whose register is read |
| rd_data | output | 32 | Register content of rd_idx |
| bus_valid | input | 1 | Bus address is valid |
| bus_addr | input | ADDR_W | Absolute bus byte address |
| bus_hit | output | 1 | Address falls in an enabled window |
| bus_cs_sel | output | NUM_CS | One-hot chip-select select |
| bus_cs_idx | output | IDX_W | Index of selected chip select |
| bus_offset | output | ADDR_W | Byte offset within the selected window |
| bus_default | output | 1 | Address hits the default region |
| err_cs0_fixed | output | 1 | Chip select 0 start was forced to base |
| err_rejected | output | 1 | Write refused as outside the window |
| err_misaligned | output | 1 | Stored window is misaligned |
| err_overlap | output | 1 | Stored window overlaps another |

## Verification
The bench builds the block with its defaults: five chip selects, a window base of 0x40 units (0x20000000), a 32-unit window, and default sizes of 8 and 4 units. With these values both refusal limits can be reached through plain register writes: an end equal to 0x40 is refused, a start of 0x60 is accepted, and 0x61 is refused. A 3-unit window at 0x5B gives a non-power-of-two misalignment. Moving chip select 0 over chip select 1 shows the overlap flag and the decode priority on the same window layout.

// File: rtl/seg_pkg.sv
package seg_pkg;

    // One window register: end and start in 8 MB units, low half reserved.
    typedef struct packed {
        logic [7:0]  end_u;
        logic [7:0]  start_u;
        logic [15:0] rsvd;
    } seg_reg_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } wr_state_e;

endpackage

// File: rtl/seg_write_check.sv
module seg_write_check
    import seg_pkg::*;
#(
    parameter int          NUM_CS     = 5,
    parameter int          IDX_W      = 3,
    parameter logic [7:0]  WIN_BASE_U = 8'h40,
    parameter int          WIN_SIZE_U = 32
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      raw,
    input  seg_reg_t         cur [NUM_CS],
    output seg_reg_t         new_seg,
    output logic             same,
    output logic             cs0_fix,
    output logic             reject,
    output logic             misalign,
    output logic             overlap
);
    localparam logic [8:0] LIMIT_U = {1'b0, WIN_BASE_U} + 9'(WIN_SIZE_U);

    seg_reg_t    cand;
    logic [7:0]  size_u;
    logic [NUM_CS-1:0] ov;

    always_comb begin
        cand      = seg_reg_t'(raw);
        cand.rsvd = '0;
        same      = (raw == 32'(cur[idx]));
        cs0_fix   = (idx == '0) && (cand.start_u != WIN_BASE_U);
        if (cs0_fix) begin
            cand.start_u = WIN_BASE_U;
        end
        reject = ({1'b0, cand.end_u} <= {1'b0, WIN_BASE_U}) ||
                 ({1'b0, cand.start_u} > LIMIT_U);
        size_u = (cand.end_u > cand.start_u) ? (cand.end_u - cand.start_u) : 8'd0;
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_ov
        assign ov[i] = (idx != IDX_W'(i)) &&
                       (cur[i].end_u > cur[i].start_u) &&
                       (size_u != 8'd0) &&
                       (cand.end_u > cur[i].start_u) &&
                       (cand.start_u < cur[i].end_u);
    end

    assign misalign = !reject && (size_u != 8'd0) && ((cand.start_u % size_u) != 8'd0);
    assign overlap  = !reject && (|ov);
    assign new_seg  = cand;

endmodule

// File: rtl/seg_addr_decode.sv
module seg_addr_decode #(
    parameter int NUM_CS     = 5,
    parameter int IDX_W      = 3,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 23
) (
    input  logic [7:0]        start_u [NUM_CS],
    input  logic [7:0]        end_u   [NUM_CS],
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output logic [NUM_CS-1:0] sel,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] offset,
    output logic              dflt
);
    localparam int UW = ADDR_W - UNIT_SHIFT;

    logic [UW:0]        addr_u;
    logic [NUM_CS-1:0]  match;
    logic [ADDR_W-1:0]  win_base;

    assign addr_u = {1'b0, bus_addr[ADDR_W-1:UNIT_SHIFT]};

    for (genvar i = 0; i < NUM_CS; i++) begin : g_match
        assign match[i] = (end_u[i] > start_u[i]) &&
                          (addr_u >= (UW+1)'(start_u[i])) &&
                          (addr_u <  (UW+1)'(end_u[i]));
    end

    always_comb begin
        idx = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
        hit      = bus_valid && (|match);
        dflt     = bus_valid && !(|match);
        win_base = ADDR_W'(start_u[idx]) << UNIT_SHIFT;
        sel      = hit ? (NUM_CS'(1) << idx) : '0;
        offset   = hit ? (bus_addr - win_base) : '0;
        if (!hit) begin
            idx = '0;
        end
    end

endmodule

// File: rtl/cs_segment_decoder.sv
module cs_segment_decoder
    import seg_pkg::*;
#(
    parameter int          NUM_CS     = 5,
    parameter int          ADDR_W     = 32,
    parameter int          UNIT_SHIFT = 23,
    parameter logic [7:0]  WIN_BASE_U = 8'h40,
    parameter int          WIN_SIZE_U = 32,
    parameter int          CS0_DEF_U  = 8,
    parameter int          CSN_DEF_U  = 4,
    localparam int         IDX_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_data,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_hit,
    output logic [NUM_CS-1:0] bus_cs_sel,
    output logic [IDX_W-1:0]  bus_cs_idx,
    output logic [ADDR_W-1:0] bus_offset,
    output logic              bus_default,
    output logic              err_cs0_fixed,
    output logic              err_rejected,
    output logic              err_misaligned,
    output logic              err_overlap
);

    function automatic seg_reg_t default_seg(input int i);
        int s;
        int e;
        s = (i == 0) ? int'(WIN_BASE_U) : int'(WIN_BASE_U) + CS0_DEF_U + (i - 1) * CSN_DEF_U;
        e = s + ((i == 0) ? CS0_DEF_U : CSN_DEF_U);
        default_seg = '{end_u: 8'(e), start_u: 8'(s), rsvd: 16'h0};
    endfunction

    wr_state_e         state_q, state_d;
    seg_reg_t          seg_q [NUM_CS];
    logic [IDX_W-1:0]  pend_idx_q;
    logic [31:0]       pend_data_q;
    logic              wr_accept;

    seg_reg_t          chk_new;
    logic              chk_same, chk_cs0, chk_rej, chk_mis, chk_ovl;
    logic [7:0]        start_u [NUM_CS];
    logic [7:0]        end_u   [NUM_CS];

    assign wr_accept = wr_en && (int'(wr_idx) < NUM_CS);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_fields
        assign start_u[i] = seg_q[i].start_u;
        assign end_u[i]   = seg_q[i].end_u;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = wr_accept ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_d = wr_accept ? ST_APPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    seg_write_check #(
        .NUM_CS(NUM_CS), .IDX_W(IDX_W),
        .WIN_BASE_U(WIN_BASE_U), .WIN_SIZE_U(WIN_SIZE_U)
    ) u_check (
        .idx(pend_idx_q), .raw(pend_data_q), .cur(seg_q),
        .new_seg(chk_new), .same(chk_same), .cs0_fix(chk_cs0),
        .reject(chk_rej), .misalign(chk_mis), .overlap(chk_ovl)
    );

    // Capture, commit and flag outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                seg_q[i] <= default_seg(i);
            end
            pend_idx_q     <= '0;
            pend_data_q    <= '0;
            err_cs0_fixed  <= 1'b0;
            err_rejected   <= 1'b0;
            err_misaligned <= 1'b0;
            err_overlap    <= 1'b0;
        end else begin
            err_cs0_fixed  <= 1'b0;
            err_rejected   <= 1'b0;
            err_misaligned <= 1'b0;
            err_overlap    <= 1'b0;
            if (wr_accept) begin
                pend_idx_q  <= wr_idx;
                pend_data_q <= wr_data;
            end
            unique case (state_q)
                ST_IDLE: ;
                ST_APPLY: begin
                    if (!chk_same) begin
                        err_cs0_fixed  <= chk_cs0;
                        err_rejected   <= chk_rej;
                        err_misaligned <= chk_mis;
                        err_overlap    <= chk_ovl;
                        if (!chk_rej) begin
                            seg_q[pend_idx_q] <= chk_new;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_CS) begin
            rd_data = 32'(seg_q[rd_idx]);
        end
    end

    seg_addr_decode #(
        .NUM_CS(NUM_CS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_decode (
        .start_u(start_u), .end_u(end_u),
        .bus_valid(bus_valid), .bus_addr(bus_addr),
        .hit(bus_hit), .sel(bus_cs_sel), .idx(bus_cs_idx),
        .offset(bus_offset), .dflt(bus_default)
    );

endmodule

// File: rtl/cs_segment_decoder_chk.sv
module cs_segment_decoder_chk #(
    parameter int          NUM_CS     = 5,
    parameter int          IDX_W      = 3,
    parameter logic [7:0]  WIN_BASE_U = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [31:0]       rd_data,
    input logic              bus_valid,
    input logic              bus_hit,
    input logic [NUM_CS-1:0] bus_cs_sel,
    input logic              bus_default,
    input logic              err_cs0_fixed,
    input logic              err_rejected,
    input logic              err_misaligned,
    input logic              err_overlap
);

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_cs_sel));

    p_hit_or_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_hit != bus_default));

    p_quiet_when_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!bus_default && !bus_hit && bus_cs_sel == '0));

    p_reject_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_rejected |-> (!err_misaligned && !err_overlap));

    p_flag_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cs0_fixed || err_rejected || err_misaligned || err_overlap) |-> $past(wr_en, 2));

    p_low_half_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:0] == 16'h0);

    p_cs0_start_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |-> (rd_data[23:16] == WIN_BASE_U));

endmodule

bind cs_segment_decoder cs_segment_decoder_chk #(
    .NUM_CS(NUM_CS), .IDX_W(IDX_W), .WIN_BASE_U(WIN_BASE_U)
) u_chk (.*);

// File: tb/tb_cs_segment_decoder.sv
`timescale 1ns/1ps
module tb_cs_segment_decoder;

    localparam int NUM_CS = 5;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [31:0]       wr_data = '0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [31:0]       rd_data;
    logic              bus_valid = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic              bus_hit;
    logic [NUM_CS-1:0] bus_cs_sel;
    logic [IDX_W-1:0]  bus_cs_idx;
    logic [31:0]       bus_offset;
    logic              bus_default;
    logic              err_cs0_fixed, err_rejected, err_misaligned, err_overlap;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    cs_segment_decoder dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] val);
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        #1 val = rd_data;
    endtask

    // flags packed as {cs0_fixed, rejected, misaligned, overlap}
    task automatic write_reg(input int idx, input logic [31:0] data, output logic [3:0] flags);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1 flags = {err_cs0_fixed, err_rejected, err_misaligned, err_overlap};
    endtask

    task automatic decode(input string req, input logic [31:0] addr, input logic exp_hit,
                          input int exp_idx, input logic [31:0] exp_off);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = addr;
        #1;
        chk(req, "hit", 32'(bus_hit), 32'(exp_hit));
        chk(req, "default", 32'(bus_default), 32'(!exp_hit));
        chk(req, "cs_sel", 32'(bus_cs_sel), exp_hit ? (32'd1 << exp_idx) : 32'd0);
        chk(req, "cs_idx", 32'(bus_cs_idx), exp_hit ? 32'(exp_idx) : 32'd0);
        chk(req, "offset", bus_offset, exp_hit ? exp_off : 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [31:0] exp_r [NUM_CS] = '{32'h48400000, 32'h4C480000, 32'h504C0000,
                                        32'h54500000, 32'h58540000};
        for (int i = 0; i < NUM_CS; i++) begin
            read_reg(i, v);
            chk("R1", "reset value", v, exp_r[i]);
        end
        read_reg(7, v);
        chk("R2", "out-of-range read", v, 32'h0);
        chk("R1", "reset flags",
            32'({err_cs0_fixed, err_rejected, err_misaligned, err_overlap}), 32'h0);
    endtask

    task automatic t_decode_defaults();
        decode("R9", 32'h20000010, 1'b1, 0, 32'h00000010);
        decode("R9", 32'h24000004, 1'b1, 1, 32'h00000004);
        decode("R9", 32'h2A7FFFFC, 1'b1, 4, 32'h007FFFFC);
        decode("R10", 32'h2C000000, 1'b0, 0, 32'h0);
        decode("R10", 32'h10000000, 1'b0, 0, 32'h0);
        @(negedge clk);
        bus_valid = 1'b0;
        #1 chk("R10", "idle default", 32'({bus_default, bus_hit}), 32'h0);
    endtask

    task automatic t_plain_write();
        logic [3:0] f;
        logic [31:0] v;
        write_reg(3, 32'h5A58ABCD, f);
        read_reg(3, v);
        chk("R3", "flags on clean write", 32'(f), 32'h0);
        chk("R2", "low half cleared", v, 32'h5A580000);
        @(posedge clk); #1;
        chk("R3", "flags one cycle only",
            32'({err_cs0_fixed, err_rejected, err_misaligned, err_overlap}), 32'h0);
    endtask

    task automatic t_cs0_fix();
        logic [3:0] f;
        logic [31:0] v;
        write_reg(0, 32'h50300000, f);
        read_reg(0, v);
        chk("R4", "cs0 stored", v, 32'h50400000);
        chk("R4", "cs0 flag", 32'(f[3]), 32'h1);
        chk("R7", "overlap flag", 32'(f[0]), 32'h1);
        decode("R11", 32'h24000000, 1'b1, 0, 32'h04000000);
    endtask

    task automatic t_reject();
        logic [3:0] f;
        logic [31:0] v;
        write_reg(2, 32'h40380000, f);
        read_reg(2, v);
        chk("R5", "end at base kept", v, 32'h504C0000);
        chk("R5", "end at base flags", 32'(f), 32'b0100);
        write_reg(2, 32'h70610000, f);
        read_reg(2, v);
        chk("R5", "start past limit kept", v, 32'h504C0000);
        chk("R5", "start past limit flag", 32'(f[2]), 32'h1);
        write_reg(2, 32'h62600000, f);
        read_reg(2, v);
        chk("R5", "start at limit stored", v, 32'h62600000);
        chk("R5", "start at limit flags", 32'(f), 32'h0);
        decode("R9", 32'h30000000, 1'b1, 2, 32'h0);
    endtask

    task automatic t_misalign_and_equal();
        logic [3:0] f;
        logic [31:0] v;
        write_reg(4, 32'h5E5B0000, f);
        read_reg(4, v);
        chk("R6", "misaligned stored", v, 32'h5E5B0000);
        chk("R6", "misaligned flags", 32'(f), 32'b0010);
        write_reg(4, 32'h5E5B0000, f);
        read_reg(4, v);
        chk("R8", "equal write value", v, 32'h5E5B0000);
        chk("R8", "equal write no flags", 32'(f), 32'h0);
    endtask

    task automatic t_disabled();
        logic [3:0] f;
        logic [31:0] v;
        decode("R9", 32'h2C000000, 1'b1, 3, 32'h0);
        write_reg(3, 32'h58580000, f);
        read_reg(3, v);
        chk("R12", "empty window stored", v, 32'h58580000);
        chk("R12", "empty window no flags", 32'(f), 32'h0);
        decode("R12", 32'h2C000000, 1'b0, 0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode_defaults();
        t_plain_write();
        t_cs0_fix();
        t_reject();
        t_misalign_and_equal();
        t_disabled();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule